// File: doc/BRIEF.md
# Hit-Map Event Readout Buffer

This block holds finished events for one front-end module until a bus-side reader collects them. For each accepted trigger the write side opens an event with its trigger number. It then takes per-channel encoded results from the digitizers, and a close pulse commits the event. Each event has three separately addressed regions: the trigger number, a hit map with one bit per channel, and the channel data words. A channel's hit bit is set when the last result written for that channel is nonzero.

The reader issues single read strobes with a region address. The oldest committed event answers the trigger-number and hit-map reads. Data reads come from a stream port, and a sequencer picks the next channel for each read. In sparse mode it visits only the channels whose hit bit is set, in ascending order. In full mode it returns every channel, zeros included. Each data word carries its channel number. After the last word, the stream returns an end marker. Reading that marker releases the event's slot, so the next event becomes the oldest. Up to eight events can be stored. When all slots are committed, new events are refused and a full flag is raised.

Top module: `hitmap_event_buffer`

## Requirements
- R1: After reset, full is 0 and rd_valid is 0. A trigger or hit-map read returns 0, and a data read returns the end marker (bit 31 set, all other bits 0).
- R2: A read strobe with rd_addr=0 returns the trigger number of the oldest committed event, zero-extended to 32 bits.
- R3: A read with rd_addr=1 returns the oldest event's hit map. Bit n is 1 exactly when the last value written to channel n while that event was open was nonzero.
- R4: A data read (rd_addr=2) with rd_sparse=1 returns the hit channels in ascending index order. Each word has bit 31 = 0, the channel index in bits 20:16, and the stored value in bits 15:0.
- R5: A data read with rd_sparse=0 returns channels 0 to 31 in order, in the same word layout. Channels without a hit bit read as value 0.
- R6: The data read after an event's last word returns the end marker. Reading the marker releases the event. An event whose hit map is empty returns the marker on its first sparse read.
- R7: A data read while no event is committed returns the end marker and changes nothing.
- R8: Eight committed events can be held, and full is 1 while all eight are committed. An event opened while full is dropped entirely, and full clears when one event is released.
- R9: Channel writes and close pulses given while no event is open have no effect.
- R10: rd_valid is 1 in exactly the cycle after each read strobe, and rd_data is valid in that cycle.
- R11: Events are read out in the order they were committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_open | input | 1 | Open a new event (ignored while full or already open) |
| evt_trig | input | 16 | Trigger number captured on open |
| ch_we | input | 1 | Channel result write strobe |
| ch_sel | input | 5 | Channel index of the result |
| ch_val | input | 16 | Encoded channel result |
| evt_close | input | 1 | Commit the open event |
| full | output | 1 | All event slots are committed |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | 2 | Region: 0 trigger, 1 hit map, 2 data stream, 3 reads 0 |
| rd_sparse | input | 1 | 1 selects sparse, 0 selects full data readout |
| rd_valid | output | 1 | rd_data holds the answer to the previous strobe |
| rd_data | output | 32 | Read result |

## Verification
A corrupted hit bit shows up on the next hit-map read of that event. It also shows up in the next sparse walk, as a skipped or extra channel word. A cursor that does not return to zero after the marker misaligns the first word of the following event. A slot pointer or occupancy counter that drifts shows up as a wrong trigger number or a stuck full flag. This appears within the first read of the next event, or when the eighth event is committed.

// File: rtl/hmeb_pkg.sv
package hmeb_pkg;
  typedef enum logic [1:0] {
    REG_TRIG = 2'd0,
    REG_HMAP = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } rd_region_e;

  typedef enum logic [1:0] {
    OUT_ZERO = 2'd0,
    OUT_META = 2'd1,
    OUT_WORD = 2'd2,
    OUT_MARK = 2'd3
  } out_sel_e;
endpackage

// File: rtl/hmeb_slots.sv
module hmeb_slots #(
  parameter int NEV = 8,
  localparam int SW = $clog2(NEV),
  localparam int CNTW = $clog2(NEV + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            evt_open,
  input  logic            evt_close,
  input  logic            release_evt,
  output logic            open_ok,
  output logic            wopen,
  output logic [SW-1:0]   wslot,
  output logic [SW-1:0]   rslot,
  output logic [CNTW-1:0] ev_cnt
);
  logic close_ok;

  function automatic logic [SW-1:0] nxt(input logic [SW-1:0] p);
    return (p == SW'(NEV - 1)) ? '0 : p + SW'(1);
  endfunction

  assign open_ok  = evt_open && !wopen && (ev_cnt < CNTW'(NEV));
  assign close_ok = evt_close && wopen;

  always_ff @(posedge clk) begin
    if (rst) begin
      wopen  <= 1'b0;
      wslot  <= '0;
      rslot  <= '0;
      ev_cnt <= '0;
    end else begin
      if (open_ok) wopen <= 1'b1;
      if (close_ok) begin
        wopen <= 1'b0;
        wslot <= nxt(wslot);
      end
      if (release_evt) rslot <= nxt(rslot);
      if (close_ok && !release_evt)      ev_cnt <= ev_cnt + CNTW'(1);
      else if (!close_ok && release_evt) ev_cnt <= ev_cnt - CNTW'(1);
    end
  end
endmodule

// File: rtl/hmeb_meta.sv
module hmeb_meta #(
  parameter int NEV = 8,
  parameter int NCH = 32,
  parameter int TW  = 16,
  localparam int SW = $clog2(NEV),
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           open_ok,
  input  logic [SW-1:0]  wslot,
  input  logic [TW-1:0]  trig_in,
  input  logic           ch_wr,
  input  logic [CW-1:0]  ch_sel,
  input  logic           ch_nz,
  input  logic [SW-1:0]  rslot,
  output logic [TW-1:0]  trig_out,
  output logic [NCH-1:0] hmap_out
);
  logic [TW-1:0]  trig_mem [NEV];
  logic [NCH-1:0] hmap_mem [NEV];

  always_ff @(posedge clk) begin
    if (open_ok) begin
      trig_mem[wslot] <= trig_in;
      hmap_mem[wslot] <= '0;
    end
    if (ch_wr) hmap_mem[wslot][ch_sel] <= ch_nz;
  end

  assign trig_out = trig_mem[rslot];
  assign hmap_out = hmap_mem[rslot];
endmodule

// File: rtl/hmeb_dmem.sv
module hmeb_dmem #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/hmeb_seq.sv
module hmeb_seq #(
  parameter int NCH = 32,
  localparam int CW = $clog2(NCH),
  localparam int UW = CW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic           sparse,
  input  logic [NCH-1:0] hmap,
  output logic           hit,
  output logic [CW-1:0]  chan
);
  logic [UW-1:0] cur;

  // lowest channel at or above the cursor; loop runs high to low so the last match wins
  always_comb begin
    hit  = 1'b0;
    chan = '0;
    if (sparse) begin
      for (int i = NCH - 1; i >= 0; i--) begin
        if (hmap[i] && (UW'(i) >= cur)) begin
          hit  = 1'b1;
          chan = CW'(i);
        end
      end
    end else begin
      hit  = cur < UW'(NCH);
      chan = cur[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       cur <= '0;
    else if (step) cur <= hit ? ({1'b0, chan} + UW'(1)) : '0;
  end
endmodule

// File: rtl/hitmap_event_buffer.sv
module hitmap_event_buffer
  import hmeb_pkg::*;
#(
  parameter int NCH = 32,
  parameter int NEV = 8,
  parameter int DW  = 16,
  parameter int TW  = 16,
  localparam int CW   = $clog2(NCH),
  localparam int SW   = $clog2(NEV),
  localparam int CNTW = $clog2(NEV + 1),
  localparam int RW   = (NCH > DW + CW + 1) ? NCH : DW + CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_open,
  input  logic [TW-1:0] evt_trig,
  input  logic          ch_we,
  input  logic [CW-1:0] ch_sel,
  input  logic [DW-1:0] ch_val,
  input  logic          evt_close,
  output logic          full,
  input  logic          rd_stb,
  input  logic [1:0]    rd_addr,
  input  logic          rd_sparse,
  output logic          rd_valid,
  output logic [RW-1:0] rd_data
);
  logic            open_ok, wopen, have_evt, ch_wr, step, rel;
  logic [SW-1:0]   wslot, rslot;
  logic [CNTW-1:0] ev_cnt;
  logic [TW-1:0]   trig_out;
  logic [NCH-1:0]  hmap_out;
  logic            seq_hit;
  logic [CW-1:0]   seq_chan;
  logic [DW-1:0]   dq;
  rd_region_e      region;

  out_sel_e        sel_q;
  logic [RW-1:0]   meta_q;
  logic [CW-1:0]   chan_q;
  logic            nz_q;

  assign have_evt = (ev_cnt != '0);
  assign full     = (ev_cnt == CNTW'(NEV));
  assign ch_wr    = ch_we && wopen;
  assign region   = rd_region_e'(rd_addr);
  assign step     = rd_stb && (region == REG_DATA) && have_evt;
  assign rel      = step && !seq_hit;

  hmeb_slots #(.NEV(NEV)) u_slots (
    .clk(clk), .rst(rst), .evt_open(evt_open), .evt_close(evt_close),
    .release_evt(rel), .open_ok(open_ok), .wopen(wopen),
    .wslot(wslot), .rslot(rslot), .ev_cnt(ev_cnt)
  );

  hmeb_meta #(.NEV(NEV), .NCH(NCH), .TW(TW)) u_meta (
    .clk(clk), .open_ok(open_ok), .wslot(wslot), .trig_in(evt_trig),
    .ch_wr(ch_wr), .ch_sel(ch_sel), .ch_nz(ch_val != '0),
    .rslot(rslot), .trig_out(trig_out), .hmap_out(hmap_out)
  );

  hmeb_seq #(.NCH(NCH)) u_seq (
    .clk(clk), .rst(rst), .step(step), .sparse(rd_sparse),
    .hmap(hmap_out), .hit(seq_hit), .chan(seq_chan)
  );

  hmeb_dmem #(.AW(SW + CW), .DW(DW)) u_dmem (
    .clk(clk), .we(ch_wr), .waddr({wslot, ch_sel}), .wdata(ch_val),
    .re(step && seq_hit), .raddr({rslot, seq_chan}), .rdata(dq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      sel_q    <= OUT_ZERO;
      meta_q   <= '0;
      chan_q   <= '0;
      nz_q     <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) begin
        unique case (region)
          REG_TRIG: begin
            sel_q  <= have_evt ? OUT_META : OUT_ZERO;
            meta_q <= RW'(trig_out);
          end
          REG_HMAP: begin
            sel_q  <= have_evt ? OUT_META : OUT_ZERO;
            meta_q <= RW'(hmap_out);
          end
          REG_DATA: begin
            sel_q  <= (have_evt && seq_hit) ? OUT_WORD : OUT_MARK;
            chan_q <= seq_chan;
            nz_q   <= hmap_out[seq_chan];
          end
          default: sel_q <= OUT_ZERO;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (sel_q)
      OUT_META: rd_data = meta_q;
      OUT_WORD: begin
        rd_data[DW-1:0]       = nz_q ? dq : '0;
        rd_data[DW+CW-1:DW]   = chan_q;
      end
      OUT_MARK: rd_data[RW-1] = 1'b1;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/hmeb_chk.sv
module hmeb_chk #(
  parameter int NEV = 8,
  parameter int DW  = 16,
  parameter int RW  = 32,
  localparam int CNTW = $clog2(NEV + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            rd_stb,
  input logic [1:0]      rd_addr,
  input logic            rd_sparse,
  input logic            rd_valid,
  input logic [RW-1:0]   rd_data,
  input logic            full,
  input logic [CNTW-1:0] ev_cnt
);
  logic data_q, sparse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= 1'b0;
      sparse_q <= 1'b0;
    end else begin
      data_q   <= rd_stb && (rd_addr == 2'd2);
      sparse_q <= rd_sparse;
    end
  end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_valid);

  assert_no_stray_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> !rd_valid);

  assert_marker_clean_R6: assert property (@(posedge clk) disable iff (rst)
    (data_q && rd_valid && rd_data[RW-1]) |-> (rd_data[RW-2:0] == '0));

  assert_sparse_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    (data_q && sparse_q && rd_valid && !rd_data[RW-1]) |-> (rd_data[DW-1:0] != '0));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    ev_cnt <= CNTW'(NEV));

  assert_full_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (full && !(rd_stb && (rd_addr == 2'd2))) |=> full);
endmodule

bind hitmap_event_buffer hmeb_chk #(.NEV(NEV), .DW(DW), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_addr(rd_addr),
  .rd_sparse(rd_sparse), .rd_valid(rd_valid), .rd_data(rd_data),
  .full(full), .ev_cnt(ev_cnt)
);

// File: tb/sim_hitmap_event_buffer.sv
`timescale 1ns/1ps
module sim_hitmap_event_buffer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_open = 0, ch_we = 0, evt_close = 0, rd_stb = 0, rd_sparse = 0;
  logic [15:0] evt_trig = '0, ch_val = '0;
  logic [4:0]  ch_sel = '0;
  logic [1:0]  rd_addr = '0;
  logic        full, rd_valid;
  logic [31:0] rd_data;

  int nchk = 0, nerr = 0;
  bit done = 0;
  localparam logic [31:0] MARK = 32'h8000_0000;

  // table rows: {channel[20:16], value[15:0]}
  localparam logic [20:0] TBL [12] = '{
    {5'd3,  16'h0011}, {5'd0,  16'h0A0A}, {5'd31, 16'hFFFF}, {5'd7,  16'h0000},
    {5'd15, 16'h1234}, {5'd16, 16'h0001}, {5'd3,  16'h0022}, {5'd20, 16'h0000},
    {5'd20, 16'h0500}, {5'd9,  16'h0077}, {5'd9,  16'h0000}, {5'd30, 16'h4000}
  };

  logic [15:0] mv [32];
  logic [31:0] mh;

  always #2 clk = ~clk;

  hitmap_event_buffer u0 (
    .clk(clk), .rst(rst), .evt_open(evt_open), .evt_trig(evt_trig),
    .ch_we(ch_we), .ch_sel(ch_sel), .ch_val(ch_val), .evt_close(evt_close),
    .full(full), .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_sparse(rd_sparse),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic sp, output logic [31:0] d);
    @(negedge clk);
    rd_stb = 1; rd_addr = a; rd_sparse = sp;
    @(negedge clk);
    rd_stb = 0;
    d = rd_data;
    chk("R10 rd_valid after strobe", {31'd0, rd_valid}, 32'd1);
  endtask

  task automatic ev_open(input logic [15:0] t);
    @(negedge clk); evt_open = 1; evt_trig = t;
    @(negedge clk); evt_open = 0;
  endtask

  task automatic ev_wr(input logic [4:0] c, input logic [15:0] v);
    @(negedge clk); ch_we = 1; ch_sel = c; ch_val = v;
    @(negedge clk); ch_we = 0;
  endtask

  task automatic ev_close();
    @(negedge clk); evt_close = 1;
    @(negedge clk); evt_close = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 full after reset", {31'd0, full}, 32'd0);
    chk("R1 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
    rd(2'd0, 1, d); chk("R1 trigger empty", d, 32'd0);
    rd(2'd1, 1, d); chk("R1 hitmap empty", d, 32'd0);
    rd(2'd2, 1, d); chk("R1 R7 data empty gives marker", d, MARK);
    @(negedge clk);
    chk("R10 rd_valid drops", {31'd0, rd_valid}, 32'd0);

    // R9 writes without an open event
    ev_wr(5'd4, 16'h5555);
    ev_close();
    rd(2'd1, 1, d); chk("R9 hitmap untouched", d, 32'd0);
    rd(2'd2, 0, d); chk("R9 no event committed", d, MARK);

    // table-driven event, model computed here
    for (int c = 0; c < 32; c++) mv[c] = '0;
    mh = '0;
    ev_open(16'h1234);
    for (int i = 0; i < 12; i++) begin
      ev_wr(TBL[i][20:16], TBL[i][15:0]);
      mv[TBL[i][20:16]] = TBL[i][15:0];
      mh[TBL[i][20:16]] = (TBL[i][15:0] != 0);
    end
    ev_close();
    rd(2'd0, 1, d); chk("R2 trigger number", d, 32'h0000_1234);
    rd(2'd1, 1, d); chk("R3 hitmap last-write", d, mh);
    for (int c = 0; c < 32; c++) begin
      if (mh[c]) begin
        rd(2'd2, 1, d);
        chk("R4 sparse word", d, (32'(c) << 16) | 32'(mv[c]));
      end
    end
    rd(2'd2, 1, d); chk("R6 marker after sparse", d, MARK);
    rd(2'd0, 1, d); chk("R6 event released", d, 32'd0);

    // full-mode event
    ev_open(16'hBEEF);
    ev_wr(5'd1, 16'h0101);
    ev_wr(5'd31, 16'h7FFF);
    ev_wr(5'd5, 16'h0000);
    ev_close();
    for (int c = 0; c < 32; c++) begin
      rd(2'd2, 0, d);
      chk("R5 full word", d, (32'(c) << 16) |
          ((c == 1) ? 32'h0101 : (c == 31) ? 32'h7FFF : 32'h0));
    end
    rd(2'd2, 0, d); chk("R6 marker after full", d, MARK);
    rd(2'd2, 0, d); chk("R7 marker on empty", d, MARK);

    // R8 R11 fill all slots
    for (int k = 0; k < 8; k++) begin
      ev_open(16'h0100 + 16'(k));
      ev_wr(5'(k * 4), 16'h0010 + 16'(k));
      ev_close();
    end
    @(negedge clk);
    chk("R8 full with eight", {31'd0, full}, 32'd1);
    ev_open(16'hDEAD);
    ev_wr(5'd0, 16'h9999);
    ev_close();
    chk("R8 still full", {31'd0, full}, 32'd1);
    for (int k = 0; k < 8; k++) begin
      rd(2'd0, 1, d); chk("R11 trigger order", d, 32'h0100 + 32'(k));
      rd(2'd1, 1, d); chk("R3 hitmap single", d, 32'd1 << (k * 4));
      rd(2'd2, 1, d); chk("R4 R11 sparse word", d, (32'(k * 4) << 16) | (32'h10 + 32'(k)));
      rd(2'd2, 1, d); chk("R6 marker", d, MARK);
      if (k == 0) chk("R8 full clears", {31'd0, full}, 32'd0);
    end
    rd(2'd0, 1, d); chk("R8 refused event absent", d, 32'd0);
    rd(2'd2, 1, d); chk("R8 no data left", d, MARK);

    // empty hit map
    ev_open(16'h0042);
    ev_wr(5'd3, 16'h0000);
    ev_close();
    rd(2'd1, 1, d); chk("R3 zero value no hit", d, 32'd0);
    rd(2'd0, 1, d); chk("R2 trigger 0042", d, 32'h42);
    rd(2'd2, 1, d); chk("R6 empty event marker", d, MARK);
    rd(2'd0, 1, d); chk("R6 empty event released", d, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule